// File: doc/BRIEF.md
# Multiword Padded Rank Filter Core

This block is the ranking engine of a two-dimensional rank-order filter. Each accepted beat carries NI new samples. A window column is WV samples high, and it arrives over CPC = ceil(WV/NI) beats. When WV is not a multiple of NI, the unused slots of the last beat carry filler samples. Their values do not matter. The window spans WH columns, so the virtual kernel holds VK = CPC·NI·WH positions, while TAP = WV·WH of those positions hold real samples.

Every position keeps a row of comparison bits. On each beat the rows shift by NI positions, and new bits are formed by comparing the incoming samples with the surviving samples and with each other. A validity bit travels with each position. Filler positions are removed by masking the comparison bits before they are counted, and by excluding the filler rows from the match. After the last beat of a column, the block finds the real position whose count of smaller samples equals the requested rank. One cycle later it reports that position as an address into the external delay line.

Top module: `rkf_core`

## Requirements
- R1: Samples are ordered by value. Equal values are ordered by age, so the older sample counts as smaller. Within a beat, slot 0 is the oldest, and samples of an earlier beat are older than those of a later beat.
- R2: A column occupies CPC beats. Slot s of beat b carries row b·NI+s, and rows at or beyond WV are filler. in_pad bit s is 1 exactly for filler slots. With the defaults (WV=3, NI=2), beat 0 has no filler and beat 1 has slot 1 as filler.
- R3: out_addr encodes a virtual-kernel position as col·VH + row, where VH = CPC·NI. Column 0 is the oldest of the WH columns in the window. With the defaults VH=4 and VK=12, and out_addr never points at a filler position.
- R4: For a rank r, out_addr names the real sample with exactly r real samples before it in the R1 order. Filler sample values have no effect on the result.
- R5: out_vld is high for exactly one cycle, on the cycle after the last beat of a column is accepted. This happens only once WH columns have entered since reset.
- R6: A rank_sel value of TAP or more (TAP=9 by default) produces no out_vld pulse.
- R7: Cycles with in_vld low, including those between beats of one column, change neither the window nor the beat phase.
- R8: Reset clears out_vld and out_addr to 0, empties the window and returns the beat phase to 0. After reset, WH new columns are needed before the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Beat accepted this cycle |
| in_data | input | NI·DW | Slot s in bits [s·DW +: DW] |
| in_pad | input | NI | Per-slot filler marker, 1 = filler |
| rank_sel | input | clog2(TAP) | Requested rank, held from the last beat of a column through the output cycle |
| out_vld | output | 1 | Ranked address available |
| out_addr | output | clog2(VK) | Virtual-kernel position of the ranked sample |

## Verification
The checker assumes that in_pad always carries the filler pattern implied by the current beat phase. The bench meets this by building every column from fixed beat templates, in which the filler slot is marked and filled with an arbitrary value. The checker also assumes that rank_sel stays steady from the last beat of a column to the output cycle. The bench therefore sets the rank before the column's first beat and holds it until the result has been checked. Idle gaps, out-of-range ranks, heavy ties and a mid-stream reset are all driven in ways that respect these two assumptions.

// File: rtl/rkf_pkg.sv
package rkf_pkg;
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/rkf_phase_ctl.sv
module rkf_phase_ctl #(
   parameter int WV = 3,
   parameter int WH = 3,
   parameter int NI = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   output logic          col_done,
   output logic          win_full,
   output logic [NI-1:0] pad_exp
);
   localparam int CPC = rkf_pkg::ceil_div(WV, NI);
   localparam int PW  = (CPC > 1) ? $clog2(CPC) : 1;
   localparam int FW  = $clog2(WH + 1);

   logic [PW-1:0] phase_q;
   logic [FW-1:0] fill_q;
   logic          last_beat;

   assign last_beat = (phase_q == PW'(CPC - 1));
   assign win_full  = (fill_q == FW'(WH));

   for (genvar s = 0; s < NI; s++) begin : g_pad
      assign pad_exp[s] = ((int'(phase_q) * NI + s) >= WV);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= '0;
         fill_q   <= '0;
         col_done <= 1'b0;
      end else begin
         col_done <= in_vld && last_beat;
         if (in_vld) begin
            phase_q <= last_beat ? '0 : phase_q + 1'b1;
            if (last_beat && !win_full) fill_q <= fill_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rkf_cmp_array.sv
module rkf_cmp_array #(
   parameter int DW = 8,
   parameter int VK = 12,
   parameter int NI = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [NI*DW-1:0] in_data,
   input  logic [NI-1:0]    in_pad,
   output logic [VK-1:0]    cr_o [VK],
   output logic [VK-1:0]    live_o
);
   localparam int OLD = VK - NI;

   logic [DW-1:0] slot   [NI];
   logic [DW-1:0] d_q    [VK];
   logic [DW-1:0] d_n    [VK];
   logic [VK-1:0] cr_q   [VK];
   logic [VK-1:0] cr_n   [VK];
   logic [VK-1:0] live_q, live_n;
   logic [NI-1:0] new_lt [OLD];
   logic [NI-1:0] nn     [NI];

   for (genvar s = 0; s < NI; s++) begin : g_slot
      assign slot[s] = in_data[s*DW +: DW];
   end

   // new slot s smaller than the survivor landing at position k
   for (genvar k = 0; k < OLD; k++) begin : g_old
      for (genvar s = 0; s < NI; s++) begin : g_new
         assign new_lt[k][s] = (slot[s] < d_q[k+NI]);
      end
   end

   // nn[s][q]: slot q ranks below slot s; lower slot is older
   for (genvar s = 0; s < NI; s++) begin : g_ps
      for (genvar q = 0; q < NI; q++) begin : g_pq
         if (q == s) begin : g_self
            assign nn[s][q] = 1'b0;
         end else if (q < s) begin : g_older
            assign nn[s][q] = (slot[q] <= slot[s]);
         end else begin : g_younger
            assign nn[s][q] = (slot[q] < slot[s]);
         end
      end
   end

   always_comb begin
      d_n    = d_q;
      cr_n   = cr_q;
      live_n = live_q;
      if (in_vld) begin
         for (int k = 0; k < OLD; k++) begin
            d_n[k]    = d_q[k+NI];
            live_n[k] = live_q[k+NI];
            for (int m = 0; m < OLD; m++) cr_n[k][m] = cr_q[k+NI][m+NI];
            for (int s = 0; s < NI; s++)  cr_n[k][OLD+s] = new_lt[k][s];
         end
         for (int s = 0; s < NI; s++) begin
            d_n[OLD+s]    = slot[s];
            live_n[OLD+s] = !in_pad[s];
            for (int k = 0; k < OLD; k++) cr_n[OLD+s][k] = !new_lt[k][s];
            for (int q = 0; q < NI; q++)  cr_n[OLD+s][OLD+q] = nn[s][q];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < VK; k++) begin
            d_q[k]  <= '0;
            cr_q[k] <= '0;
         end
         live_q <= '0;
      end else begin
         d_q    <= d_n;
         cr_q   <= cr_n;
         live_q <= live_n;
      end
   end

   assign cr_o   = cr_q;
   assign live_o = live_q;
endmodule

// File: rtl/rkf_rank_sel.sv
module rkf_rank_sel #(
   parameter int VK = 12,
   parameter int RW = 4,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VK-1:0] cr_i [VK],
   input  logic [VK-1:0] live_i,
   input  logic          eval_i,
   input  logic [RW-1:0] rank_i,
   output logic          out_vld,
   output logic [AW-1:0] out_addr
);
   logic [VK-1:0] hit;
   logic [AW-1:0] idx;

   always_comb begin
      hit = '0;
      idx = '0;
      for (int i = 0; i < VK; i++) begin
         int cnt;
         cnt = 0;
         for (int j = 0; j < VK; j++) begin
            if (cr_i[i][j] && live_i[j]) cnt = cnt + 1;
         end
         hit[i] = live_i[i] && (cnt == int'(rank_i));
      end
      for (int i = 0; i < VK; i++) begin
         if (hit[i]) idx = AW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_addr <= '0;
      end else begin
         out_vld <= eval_i && (|hit);
         if (eval_i && (|hit)) out_addr <= idx;
      end
   end
endmodule

// File: rtl/rkf_core.sv
module rkf_core #(
   parameter int DW = 8,
   parameter int WV = 3,
   parameter int WH = 3,
   parameter int NI = 2,
   localparam int CPC = rkf_pkg::ceil_div(WV, NI),
   localparam int VH  = CPC * NI,
   localparam int VK  = VH * WH,
   localparam int TAP = WV * WH,
   localparam int RW  = $clog2(TAP),
   localparam int AW  = $clog2(VK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [NI*DW-1:0] in_data,
   input  logic [NI-1:0]    in_pad,
   input  logic [RW-1:0]    rank_sel,
   output logic             out_vld,
   output logic [AW-1:0]    out_addr
);
   if (DW < 1 || WV < 1 || NI < 1 || WH < 2) begin : g_bad_cfg
      $error("rkf_core: DW, WV, NI must be >= 1 and WH >= 2");
   end

   logic          col_done;
   logic          win_full;
   logic [NI-1:0] pad_exp;
   logic [VK-1:0] cr     [VK];
   logic [VK-1:0] live;

   rkf_phase_ctl #(.WV(WV), .WH(WH), .NI(NI)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .col_done (col_done),
      .win_full (win_full),
      .pad_exp  (pad_exp)
   );

   rkf_cmp_array #(.DW(DW), .VK(VK), .NI(NI)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_data (in_data),
      .in_pad  (in_pad),
      .cr_o    (cr),
      .live_o  (live)
   );

   rkf_rank_sel #(.VK(VK), .RW(RW), .AW(AW)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cr_i     (cr),
      .live_i   (live),
      .eval_i   (col_done && win_full),
      .rank_i   (rank_sel),
      .out_vld  (out_vld),
      .out_addr (out_addr)
   );
endmodule

// File: rtl/rkf_core_chk.sv
module rkf_core_chk #(
   parameter int WV  = 3,
   parameter int NI  = 2,
   parameter int CPC = 2,
   parameter int VH  = 4,
   parameter int VK  = 12,
   parameter int TAP = 9,
   parameter int RW  = 4,
   parameter int AW  = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_vld,
   input logic [NI-1:0] in_pad,
   input logic [NI-1:0] pad_exp,
   input logic          col_done,
   input logic          win_full,
   input logic [RW-1:0] rank_sel,
   input logic          out_vld,
   input logic [AW-1:0] out_addr
);
   assert_pad_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (in_pad == pad_exp));

   assert_addr_real_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((int'(out_addr) < VK) && ((int'(out_addr) % VH) < WV)));

   assert_pulse_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(col_done) && $past(win_full)));

   assert_rank_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(rank_sel) < TAP));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(pad_exp));

   if (CPC > 1) begin : g_multi_beat
      assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |=> !out_vld);
   end
endmodule

bind rkf_core rkf_core_chk #(
   .WV(WV), .NI(NI), .CPC(CPC), .VH(VH), .VK(VK), .TAP(TAP), .RW(RW), .AW(AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_pad   (in_pad),
   .pad_exp  (pad_exp),
   .col_done (col_done),
   .win_full (win_full),
   .rank_sel (rank_sel),
   .out_vld  (out_vld),
   .out_addr (out_addr)
);

// File: tb/rkf_core_test.sv
`timescale 1ns/1ps
module rkf_core_test;
   localparam int DW = 8, WV = 3, WH = 3, NI = 2;
   localparam int VH = 4, TAP = 9, RW = 4, AW = 4;
   localparam int NROW = 9;
   // v0, v1, v2, rank, idle cycles inside the column
   localparam int TBL [NROW][5] = '{
      '{ 10,  20,  30,  4, 0},
      '{  5,  50,  25,  0, 0},
      '{ 40,  40,  40,  4, 0},
      '{  7,   7,   7,  0, 2},
      '{200,   1, 100,  8, 0},
      '{  9,   9,   9,  3, 0},
      '{255,   0, 128,  4, 3},
      '{ 60,  61,  62, 12, 0},
      '{  3,   3,   3,  6, 0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_vld = 1'b0;
   logic [NI*DW-1:0] in_data = '0;
   logic [NI-1:0]    in_pad = '0;
   logic [RW-1:0]    rank_sel = '0;
   logic             out_vld;
   logic [AW-1:0]    out_addr;

   int checks = 0;
   int fails  = 0;
   int win [WH][WV];
   int cols_in = 0;

   always #10 clk = ~clk;

   rkf_core #(.DW(DW), .WV(WV), .WH(WH), .NI(NI)) uut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .in_pad(in_pad), .rank_sel(rank_sel), .out_vld(out_vld), .out_addr(out_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ref_addr(input int rank);
      for (int c = 0; c < WH; c++) begin
         for (int r = 0; r < WV; r++) begin
            int n;
            n = 0;
            for (int c2 = 0; c2 < WH; c2++) begin
               for (int r2 = 0; r2 < WV; r2++) begin
                  if (win[c2][r2] < win[c][r] ||
                      (win[c2][r2] == win[c][r] && (c2*VH + r2) < (c*VH + r))) n++;
               end
            end
            if (n == rank) return c*VH + r;
         end
      end
      return -1;
   endfunction

   task automatic send_col(input int v0, input int v1, input int v2,
                           input int rank, input int gap, input string tag);
      logic [DW-1:0] fill;
      bit exp_p;
      int exp_a;
      fill = DW'($urandom);
      rank_sel = RW'(rank);
      @(negedge clk); in_vld = 1'b1; in_data = {DW'(v1), DW'(v0)}; in_pad = 2'b00;
      @(posedge clk);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk); in_vld = 1'b0; in_data = {DW'($urandom), DW'($urandom)};
         @(posedge clk);
      end
      @(negedge clk); in_vld = 1'b1; in_data = {fill, DW'(v2)}; in_pad = 2'b10;
      @(posedge clk);
      @(negedge clk); in_vld = 1'b0; in_pad = 2'b00;
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < WH-1; c++) win[c] = win[c+1];
      win[WH-1] = '{v0, v1, v2};
      cols_in++;
      exp_p = (cols_in >= WH) && (rank < TAP);
      chk(out_vld == exp_p, {tag, " pulse R5"}, int'(out_vld), int'(exp_p));
      if (exp_p) begin
         exp_a = ref_addr(rank);
         chk(int'(out_addr) == exp_a, {tag, " address R2/R3/R4"}, int'(out_addr), exp_a);
      end
      @(negedge clk);
      chk(out_vld == 1'b0, {tag, " one-cycle pulse R5"}, int'(out_vld), 0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "reset out_vld R8", int'(out_vld), 0);
      chk(out_addr == '0, "reset out_addr R8", int'(out_addr), 0);
      rst_n = 1'b1;

      // table walk: ties (R1), idle gaps (R7), rank out of range (R6)
      for (int i = 0; i < NROW; i++) begin
         string tag;
         tag = (TBL[i][4] != 0) ? "idle-gap R7" :
               (TBL[i][3] >= TAP) ? "rank range R6" :
               (TBL[i][0] == TBL[i][1]) ? "ties R1" : "table";
         send_col(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4], tag);
      end

      // mid-stream reset: window must refill (R8)
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(out_vld == 1'b0, "mid reset out_vld R8", int'(out_vld), 0);
      chk(out_addr == '0, "mid reset out_addr R8", int'(out_addr), 0);
      rst_n = 1'b1;
      cols_in = 0;

      // all-equal window: oldest first, newest last (R1)
      send_col(5, 5, 5, 0, 0, "refill R8");
      send_col(5, 5, 5, 0, 0, "refill R8");
      send_col(5, 5, 5, 0, 0, "all equal oldest R1");
      chk(out_addr == 4'd0, "all equal rank 0 R1", int'(out_addr), 0);
      send_col(5, 5, 5, 8, 1, "all equal newest R1");
      chk(out_addr == 4'd10, "all equal rank 8 R1", int'(out_addr), 10);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule